// File: doc/BRIEF.md
# Reset Sequencing Controller with Bidirectional Reset Lines

This block orders the reset of a chip. A qualified power-on reset holds the chip in its deepest reset state. The block leaves that state once the power-on input has gone high and either the clock generator reports lock or limp operation is enabled. It then pulls two shared, active-low reset lines low for a fixed count of clock cycles. The hard line resets the whole chip and the soft line resets the core and its debug port. At the end of that count it pulses a one-cycle strobe that captures configuration from pins the chip shares with other functions.

Both reset lines are open-drain. The block only asks for a line to be pulled low, through an enable; an external pull-up brings it high. The block also reads the level on each line. A low on a line while the block is not pulling it, and after the line has been high for a blanking period, is an external reset request. The power-on input and the hard line must stay low for longer than a set time before they count, so short spikes are rejected. Internal single-cycle request strobes from elsewhere in the chip can also start a hard or a soft sequence.

The block has no data stream, so it has no valid/ready interface and no back-pressure. Each captured configuration value is registered when its strobe pulses and then holds until the next capture. Every pin is a plain control or status signal.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While the qualified power-on reset is active, and while the block waits to leave it, both `hard_pull` and `soft_pull` are 1 (line pulled low) and no configuration strobe pulses.
- R2: After the power-on input is released, the block stays in power-on reset until `pll_locked` or `limp_en` is 1. In the cycle after either is seen, the hard sequence of R4 starts.
- R3: When the qualified power-on reset ends, `mode_stb` pulses for one cycle and `mode_cfg` takes the value of `mode_pins` in that cycle.
- R4: A hard sequence holds both `hard_pull` and `soft_pull` at 1 for exactly DRIVE_CYCLES (512) consecutive cycles. `hcfg_stb` is 1 on the last of those cycles only. `hcfg_word` then holds the `data_bus` value of that cycle, and both pulls are 0 in the following cycle.
- R5: A soft sequence holds `soft_pull` at 1 for exactly 512 cycles while `hard_pull` stays 0. `dbg_stb` is 1 on the last cycle, and `dbg_cfg` then holds that cycle's `dbg_pins`.
- R6: A hard sequence starts on `int_hard_req` or on a qualified external low on `hard_pin_n`. A soft sequence starts on `int_soft_req` or on a low on `soft_pin_n`. The soft pin is only synchronised.
- R7: The block never treats the low it causes itself as an external request. After its own sequence ends, no new sequence starts unless a request arrives.
- R8: After the block releases a line, or after the line was last seen low, the line must be seen high for BLANK_CYCLES (16) samples before an external low is accepted. A low during that window is ignored.
- R9: A low on `por_pin_n` or `hard_pin_n` counts only after it has been held for QUAL_CYC samples, with QUAL_CYC = QUAL_NS/CLK_PERIOD_NS + 1 (21 at 5 ns). Shorter lows have no effect.
- R10: Priority is power-on, then hard, then soft. A hard request during a soft sequence restarts the count as a hard sequence with no debug capture. A soft request during a hard sequence is dropped. A qualified power-on reset aborts any sequence.
- R11: `hcfg_stb`, `dbg_stb` and `mode_stb` are each high for a single cycle per capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_pin_n | input | 1 | Raw active-low power-on reset pin |
| pll_locked | input | 1 | Clock generator lock flag |
| limp_en | input | 1 | Allows leaving power-on reset without lock |
| hard_pin_n | input | 1 | Level read back from the hard reset line |
| hard_pull | output | 1 | 1 = pull the hard reset line low |
| soft_pin_n | input | 1 | Level read back from the soft reset line |
| soft_pull | output | 1 | 1 = pull the soft reset line low |
| int_hard_req | input | 1 | Internal hard-reset request strobe |
| int_soft_req | input | 1 | Internal soft-reset request strobe |
| mode_pins | input | MODE_W | Mode-select inputs |
| data_bus | input | CFG_W | Data bus carrying the hard-reset configuration |
| dbg_pins | input | DBG_W | Debug-port inputs carrying the debug configuration |
| mode_stb | output | 1 | Mode capture strobe |
| mode_cfg | output | MODE_W | Captured mode bits |
| hcfg_stb | output | 1 | Hard-reset configuration capture strobe |
| hcfg_word | output | CFG_W | Captured data-bus configuration |
| dbg_stb | output | 1 | Debug configuration capture strobe |
| dbg_cfg | output | DBG_W | Captured debug configuration |

## Verification
The bench times the wait for lock and for limp mode, the length of each drive window, and where the strobe falls in it. A design that is off by one cycle shows a window of 511 or 513 cycles, or a strobe after the release. It fires reset-line lows that are too short, lows inside the blanking window, and the idle period after the block's own release. A design that does not blank its own pin would restart itself forever, and one with a weak filter would react to spikes. It also crosses requests, hard over soft, soft during hard and power-on during soft. A wrong priority shows up as a stray debug capture, a cut-short hard window, or a soft sequence run after a hard one.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  // Sequencer states; the zero encoding is the deepest reset state.
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_IDLE = 2'd1,
    ST_HARD = 2'd2,
    ST_SOFT = 2'd3
  } seq_state_e;

  // Index of each reset line inside the per-line arrays.
  localparam int unsigned LINE_HARD = 0;
  localparam int unsigned LINE_SOFT = 1;
  localparam int unsigned NUM_LINES = 2;

endpackage

// File: rtl/rst_pin_qual.sv
// Synchroniser plus low-level qualifier for one active-low input.
module rst_pin_qual #(
  parameter int unsigned QUAL_CYC = 21
) (
  input  logic clk,
  input  logic hold,
  input  logic pin_n,
  output logic low_sync,
  output logic low_q
);
  localparam int unsigned CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(QUAL_CYC);

  logic s1, s2;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    s1 <= pin_n;
    s2 <= s1;
  end

  assign low_sync = ~s2;

  // Counts consecutive low samples and saturates. Any high sample clears it,
  // so the counter settles from any start value without its own reset.
  always_ff @(posedge clk) begin
    if (hold || !low_sync)   run_cnt <= '0;
    else if (run_cnt != CMAX) run_cnt <= run_cnt + 1'b1;
  end

  assign low_q = (run_cnt == CMAX);

  // R9: a qualified low needs the line low in the previous sample as well.
  a_r9_qual_needs_low: assert property (@(posedge clk) disable iff (hold)
    low_q |-> $past(low_sync));

endmodule

// File: rtl/rst_pin_watch.sv
// Blanking and arming for one bidirectional reset line.
module rst_pin_watch #(
  parameter int unsigned BLANK_CYC = 16
) (
  input  logic clk,
  input  logic hold,
  input  logic drive,
  input  logic low_sync,
  input  logic low_q,
  output logic ext_req
);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] BLOAD = BW'(BLANK_CYC);

  logic armed;
  logic [BW-1:0] blank_cnt;

  always_ff @(posedge clk) begin
    if (hold || drive) begin
      armed     <= 1'b0;
      blank_cnt <= BLOAD;
    end else if (!armed) begin
      if (low_sync) begin
        blank_cnt <= BLOAD;
      end else if (blank_cnt <= 1) begin
        armed     <= 1'b1;
        blank_cnt <= '0;
      end else begin
        blank_cnt <= blank_cnt - 1'b1;
      end
    end
  end

  assign ext_req = armed && low_q && !drive;

  // R8: arming only follows a high sample of an undriven line.
  a_r8_arm_after_high: assert property (@(posedge clk) disable iff (hold)
    $rose(armed) |-> $past(!drive && !low_sync));

  // R7: pulling the line disarms detection in the next cycle.
  a_r7_disarm_on_drive: assert property (@(posedge clk) disable iff (hold)
    drive |=> !armed);

endmodule

// File: rtl/rst_seq_fsm.sv
// Reset sequencer: priority, shared drive counter and strobes.
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned DRIVE_CYCLES = 512
) (
  input  logic clk,
  input  logic por_active,
  input  logic pll_locked,
  input  logic limp_en,
  input  logic hard_req,
  input  logic soft_req,
  output logic hard_drive,
  output logic soft_drive,
  output logic hcfg_stb,
  output logic dbg_stb,
  output logic mode_stb
);
  localparam int unsigned CW = (DRIVE_CYCLES > 1) ? $clog2(DRIVE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DRIVE_CYCLES - 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          por_d;

  always_ff @(posedge clk) begin
    por_d <= por_active;
    if (por_active) begin
      state <= ST_HOLD;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (pll_locked || limp_en) begin
            state <= ST_HARD;
            cnt   <= '0;
          end
        end
        ST_IDLE: begin
          if (hard_req) begin
            state <= ST_HARD;
            cnt   <= '0;
          end else if (soft_req) begin
            state <= ST_SOFT;
            cnt   <= '0;
          end
        end
        ST_HARD: begin
          if (cnt == LAST) state <= ST_IDLE;
          else             cnt   <= cnt + 1'b1;
        end
        ST_SOFT: begin
          if (hard_req) begin
            state <= ST_HARD;
            cnt   <= '0;
          end else if (cnt == LAST) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  assign hard_drive = (state == ST_HOLD) || (state == ST_HARD);
  assign soft_drive = (state != ST_IDLE);
  assign hcfg_stb   = (state == ST_HARD) && (cnt == LAST);
  assign dbg_stb    = (state == ST_SOFT) && (cnt == LAST) && !hard_req;
  assign mode_stb   = por_d && !por_active;

  a_r2_hold_waits: assert property (@(posedge clk) disable iff (por_active)
    (state == ST_HOLD && !pll_locked && !limp_en) |=> state == ST_HOLD);

  a_r4_hard_ends: assert property (@(posedge clk) disable iff (por_active)
    (state == ST_HARD && cnt == LAST) |=> state == ST_IDLE);

  a_r5_soft_ends: assert property (@(posedge clk) disable iff (por_active)
    (state == ST_SOFT && cnt == LAST && !hard_req) |=> state == ST_IDLE);

  a_r10_hard_over_soft: assert property (@(posedge clk) disable iff (por_active)
    (state == ST_SOFT && hard_req) |=> (state == ST_HARD && cnt == '0));

  a_r10_soft_dropped: assert property (@(posedge clk) disable iff (por_active)
    (state == ST_HARD && cnt != LAST) |=> state == ST_HARD);

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned QUAL_NS       = 100,
  parameter int unsigned DRIVE_CYCLES  = 512,
  parameter int unsigned BLANK_CYCLES  = 16,
  parameter int unsigned MODE_W        = 3,
  parameter int unsigned CFG_W         = 32,
  parameter int unsigned DBG_W         = 2
) (
  input  logic              clk,
  input  logic              por_pin_n,
  input  logic              pll_locked,
  input  logic              limp_en,
  input  logic              hard_pin_n,
  output logic              hard_pull,
  input  logic              soft_pin_n,
  output logic              soft_pull,
  input  logic              int_hard_req,
  input  logic              int_soft_req,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic [CFG_W-1:0]  data_bus,
  input  logic [DBG_W-1:0]  dbg_pins,
  output logic              mode_stb,
  output logic [MODE_W-1:0] mode_cfg,
  output logic              hcfg_stb,
  output logic [CFG_W-1:0]  hcfg_word,
  output logic              dbg_stb,
  output logic [DBG_W-1:0]  dbg_cfg
);
  localparam int unsigned QUAL_CYC = QUAL_NS / CLK_PERIOD_NS + 1;

  logic por_active;
  logic por_sync_lo;
  logic [NUM_LINES-1:0] line_pin_n, line_pull, line_lo, line_q, line_ext;

  rst_pin_qual #(.QUAL_CYC(QUAL_CYC)) u_por_qual (
    .clk(clk), .hold(1'b0), .pin_n(por_pin_n),
    .low_sync(por_sync_lo), .low_q(por_active)
  );

  assign line_pin_n[LINE_HARD] = hard_pin_n;
  assign line_pin_n[LINE_SOFT] = soft_pin_n;
  assign line_pull[LINE_HARD]  = hard_pull;
  assign line_pull[LINE_SOFT]  = soft_pull;

  // One qualifier and watcher per line; only the hard line is filtered.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    rst_pin_qual #(.QUAL_CYC(i == LINE_HARD ? QUAL_CYC : 1)) u_qual (
      .clk(clk), .hold(por_active), .pin_n(line_pin_n[i]),
      .low_sync(line_lo[i]), .low_q(line_q[i])
    );
    rst_pin_watch #(.BLANK_CYC(BLANK_CYCLES)) u_watch (
      .clk(clk), .hold(por_active), .drive(line_pull[i]),
      .low_sync(line_lo[i]), .low_q(line_q[i]), .ext_req(line_ext[i])
    );
  end

  rst_seq_fsm #(.DRIVE_CYCLES(DRIVE_CYCLES)) u_fsm (
    .clk(clk), .por_active(por_active),
    .pll_locked(pll_locked), .limp_en(limp_en),
    .hard_req(int_hard_req || line_ext[LINE_HARD]),
    .soft_req(int_soft_req || line_ext[LINE_SOFT]),
    .hard_drive(hard_pull), .soft_drive(soft_pull),
    .hcfg_stb(hcfg_stb), .dbg_stb(dbg_stb), .mode_stb(mode_stb)
  );

  always_ff @(posedge clk) begin
    if (mode_stb) mode_cfg <= mode_pins;
  end

  always_ff @(posedge clk) begin
    if (por_active) begin
      hcfg_word <= '0;
      dbg_cfg   <= '0;
    end else begin
      if (hcfg_stb) hcfg_word <= data_bus;
      if (dbg_stb)  dbg_cfg   <= dbg_pins;
    end
  end

  a_r11_hcfg_single: assert property (@(posedge clk) disable iff (por_active)
    hcfg_stb |=> !hcfg_stb);

  a_r11_dbg_single: assert property (@(posedge clk) disable iff (por_active)
    dbg_stb |=> !dbg_stb);

  a_r3_mode_single: assert property (@(posedge clk) disable iff (por_active)
    mode_stb |=> !mode_stb);

  a_r5_soft_alone: assert property (@(posedge clk) disable iff (por_active)
    dbg_stb |-> (soft_pull && !hard_pull));

  a_r4_release_after_hcfg: assert property (@(posedge clk) disable iff (por_active)
    hcfg_stb |=> (!hard_pull && !soft_pull));

  a_r1_por_no_strobe: assert property (@(posedge clk)
    por_sync_lo && por_active |-> !hcfg_stb && !dbg_stb);

endmodule

// File: tb/rst_seq_ctrl_bench.sv
`timescale 1ns/1ps
module rst_seq_ctrl_bench;
  localparam int DRIVE = 512;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_pin_n = 1'b0, pll_locked = 1'b0, limp_en = 1'b0;
  logic ext_hard = 1'b0, ext_soft = 1'b0;
  logic int_hard_req = 1'b0, int_soft_req = 1'b0;
  logic [2:0]  mode_pins = '0;
  logic [31:0] data_bus = '0;
  logic [1:0]  dbg_pins = '0;
  logic hard_pin_n, soft_pin_n, hard_pull, soft_pull;
  logic mode_stb, hcfg_stb, dbg_stb;
  logic [2:0] mode_cfg;
  logic [31:0] hcfg_word;
  logic [1:0] dbg_cfg;

  // Open-drain lines with pull-ups.
  assign hard_pin_n = ~(hard_pull | ext_hard);
  assign soft_pin_n = ~(soft_pull | ext_soft);

  rst_seq_ctrl u_rst_seq_ctrl (
    .clk(clk), .por_pin_n(por_pin_n), .pll_locked(pll_locked), .limp_en(limp_en),
    .hard_pin_n(hard_pin_n), .hard_pull(hard_pull),
    .soft_pin_n(soft_pin_n), .soft_pull(soft_pull),
    .int_hard_req(int_hard_req), .int_soft_req(int_soft_req),
    .mode_pins(mode_pins), .data_bus(data_bus), .dbg_pins(dbg_pins),
    .mode_stb(mode_stb), .mode_cfg(mode_cfg),
    .hcfg_stb(hcfg_stb), .hcfg_word(hcfg_word),
    .dbg_stb(dbg_stb), .dbg_cfg(dbg_cfg)
  );

  int checks = 0, errors = 0;

  function automatic int exp_len(input bit hard);
    return hard ? DRIVE : DRIVE;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] bus);
    return bus;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit hard);
    if (hard) int_hard_req = 1'b1; else int_soft_req = 1'b1;
    @(negedge clk);
    int_hard_req = 1'b0; int_soft_req = 1'b0;
  endtask

  // Counts negedges until hcfg_stb is seen.
  task automatic wait_hcfg(output int n, input int limit);
    n = 0;
    do begin @(negedge clk); n++; end while (!hcfg_stb && n < limit);
  endtask

  // Counts cycles until any pull appears within 'win'.
  task automatic quiet(input string req, input string what, input int win);
    int seen = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (hard_pull || soft_pull) seen++;
    end
    chk(req, what, 64'(seen), 64'd0);
  endtask

  // Measures one drive window on the chosen line.
  task automatic run_seq(input bit hard, input logic [31:0] bus,
                         input logic [1:0] dbg, input string req);
    int w = 0, n = 0, stbs = 0, bad = 0;
    while (!(hard ? hard_pull : soft_pull) && w < 200) begin @(negedge clk); w++; end
    chk(req, "sequence started", 64'(w < 200), 64'd1);
    while ((hard ? hard_pull : soft_pull) && n < 2000) begin
      n++;
      stbs += hard ? int'(hcfg_stb) : int'(dbg_stb);
      if (hard ? !soft_pull : hard_pull) bad++;
      @(negedge clk);
    end
    chk(req, "drive length", 64'(n), 64'(exp_len(hard)));
    chk(req, "strobe count", 64'(stbs), 64'd1);
    chk(req, "other line", 64'(bad), 64'd0);
    if (hard) chk(req, "hcfg_word", 64'(hcfg_word), 64'(exp_word(bus)));
    else      chk(req, "dbg_cfg", 64'(dbg_cfg), 64'(dbg));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic [2:0] mv;
    void'($urandom(32'd20240611));
    idle(40);
    // R1: qualified power-on reset pulls both lines
    chk("R1", "hard_pull in por", 64'(hard_pull), 64'd1);
    chk("R1", "soft_pull in por", 64'(soft_pull), 64'd1);
    chk("R1", "no hcfg_stb in por", 64'(hcfg_stb), 64'd0);

    // R3: mode capture on release
    mv = 3'($urandom);
    mode_pins = mv;
    por_pin_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!mode_stb && n < 50);
    chk("R3", "mode_stb seen", 64'(mode_stb), 64'd1);
    @(negedge clk);
    chk("R11", "mode_stb single", 64'(mode_stb), 64'd0);
    chk("R3", "mode_cfg", 64'(mode_cfg), 64'(mv));

    // R2: no lock, no limp -> stays in reset
    wait_hcfg(n, 600);
    chk("R2", "no exit without lock", 64'(hcfg_stb), 64'd0);
    chk("R1", "still pulled while waiting", 64'(hard_pull & soft_pull), 64'd1);

    // R2/R4: limp exits, 512 cycles to strobe
    data_bus = $urandom;
    limp_en = 1'b1;
    wait_hcfg(n, 1000);
    chk("R4", "cycles to hcfg_stb via limp", 64'(n), 64'(DRIVE));
    chk("R4", "soft pulled at strobe", 64'(soft_pull), 64'd1);
    @(negedge clk);
    chk("R11", "hcfg_stb single", 64'(hcfg_stb), 64'd0);
    chk("R4", "hcfg_word", 64'(hcfg_word), 64'(exp_word(data_bus)));
    chk("R4", "lines released", 64'(hard_pull | soft_pull), 64'd0);
    limp_en = 1'b0;
    pll_locked = 1'b1;
    idle(40);

    // Random sequences, R5 R6
    for (int i = 0; i < 8; i++) begin
      int kind;
      logic [31:0] bus;
      logic [1:0] dv;
      kind = int'($urandom_range(0, 3));
      bus = $urandom;
      dv = 2'($urandom);
      data_bus = bus;
      dbg_pins = dv;
      case (kind)
        0: begin pulse(1'b1); run_seq(1'b1, bus, dv, "R6 int hard"); end
        1: begin pulse(1'b0); run_seq(1'b0, bus, dv, "R5 int soft"); end
        2: fork
             begin ext_hard = 1'b1; idle(40); ext_hard = 1'b0; end
             run_seq(1'b1, bus, dv, "R6 ext hard");
           join
        default: fork
             begin ext_soft = 1'b1; idle(40); ext_soft = 1'b0; end
             run_seq(1'b0, bus, dv, "R6 ext soft");
           join
      endcase
      idle(40);
    end

    // R9: short lows on hard line and power-on input are ignored
    ext_hard = 1'b1; idle(3); ext_hard = 1'b0;
    quiet("R9", "3-cycle hard glitch", 80);
    ext_hard = 1'b1; idle(15); ext_hard = 1'b0;
    quiet("R9", "75ns hard low", 80);
    por_pin_n = 1'b0; idle(10); por_pin_n = 1'b1;
    quiet("R9", "50ns por low", 80);

    // R7, R8: own release not seen; low inside blanking ignored
    data_bus = $urandom;
    pulse(1'b1);
    run_seq(1'b1, data_bus, dbg_pins, "R4 blank setup");
    quiet("R7", "no self restart", 100);
    pulse(1'b1);
    run_seq(1'b1, data_bus, dbg_pins, "R4 second");
    idle(2);
    ext_hard = 1'b1; idle(40); ext_hard = 1'b0;
    quiet("R8", "low during blanking", 80);
    fork
      begin ext_hard = 1'b1; idle(40); ext_hard = 1'b0; end
      run_seq(1'b1, data_bus, dbg_pins, "R8 armed after blank");
    join
    idle(40);

    // R10: soft request during hard is dropped
    fork
      run_seq(1'b1, data_bus, dbg_pins, "R10 hard with soft req");
      begin pulse(1'b1); idle(50); pulse(1'b0); end
    join
    quiet("R10", "soft dropped after hard", 60);

    // R10: hard request preempts soft
    begin
      int dbgs = 0, gaps = 0;
      pulse(1'b0);
      for (int k = 0; k < 100; k++) begin
        if (k > 0 && !soft_pull) gaps++;
        dbgs += int'(dbg_stb);
        @(negedge clk);
      end
      data_bus = $urandom;
      pulse(1'b1);
      run_seq(1'b1, data_bus, dbg_pins, "R10 hard restart");
      dbgs += int'(dbg_stb);
      chk("R10", "soft held before preempt", 64'(gaps), 64'd0);
      chk("R10", "no debug capture", 64'(dbgs), 64'd0);
    end
    idle(40);

    // R10: power-on reset aborts a soft sequence, R3 recapture
    pulse(1'b0);
    idle(20);
    por_pin_n = 1'b0;
    idle(40);
    chk("R10", "por pulls hard line", 64'(hard_pull), 64'd1);
    mv = mv ^ 3'b101;
    mode_pins = mv;
    data_bus = $urandom;
    por_pin_n = 1'b1;
    wait_hcfg(n, 700);
    chk("R10", "hard sequence after por", 64'(hcfg_stb), 64'd1);
    chk("R3", "mode_cfg recaptured", 64'(mode_cfg), 64'(mv));
    @(negedge clk);
    chk("R4", "hcfg after por", 64'(hcfg_word), 64'(exp_word(data_bus)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule